// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry

This block is a purely combinational 32-bit shifter that sits in an execute stage. It takes a data operand, an amount word read from a register, a 2-bit operation kind and the current carry flag. It returns the shifted value and the updated carry flag. The amount range and carry rules follow the convention for shift amounts taken from a register, not from an immediate field.

Only the low byte of the amount word counts, so the effective amount runs from 0 to 255. The carry flag is the last bit shifted out. Three cases need their own handling: a zero amount, an amount of exactly the word width, and an amount wider than the word. Rotation wraps modulo the word width. A rotation by a non-zero multiple of 32 is a special case: the value is unchanged, but the carry is still updated.

The datapath uses one right-shifting log-stage network. A left shift is done by mirroring the operand into that network and mirroring the result back out. The out-of-range cases are handled by a final selection.

Top module: `shf_reg_shifter`

## Requirements
- R1: Only bits 7:0 of `amt_i` affect either output. Changing bits 31:8 leaves `res_o` and `c_o` unchanged.
- R2: When bits 7:0 of `amt_i` are zero, `res_o` equals `opnd_i` and `c_o` equals `c_i`, for every kind.
- R3: For kind 2'b00 (logical left) with amount n from 1 to 31, `res_o` is `opnd_i << n` and `c_o` is `opnd_i[32-n]`.
- R4: For kind 2'b00 with amount 32, `res_o` is 0 and `c_o` is `opnd_i[0]`. With an amount of 33 to 255, both outputs are 0.
- R5: For kind 2'b01 (logical right) with amount n from 1 to 31, `res_o` is `opnd_i >> n` and `c_o` is `opnd_i[n-1]`.
- R6: For kind 2'b01 with amount 32, `res_o` is 0 and `c_o` is `opnd_i[31]`. With an amount of 33 to 255, both outputs are 0.
- R7: For kind 2'b10 (arithmetic right) with amount n from 1 to 31, `res_o` is `opnd_i` shifted right with sign fill and `c_o` is `opnd_i[n-1]`.
- R8: For kind 2'b10 with an amount of 32 to 255, every bit of `res_o` and `c_o` equal `opnd_i[31]`.
- R9: For kind 2'b11 (rotate right) with m = amount mod 32 non-zero, `res_o` is `opnd_i` rotated right by m and `c_o` is `opnd_i[m-1]`.
- R10: For kind 2'b11 with a non-zero amount that is a multiple of 32, `res_o` equals `opnd_i` and `c_o` is `opnd_i[31]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Value to be shifted |
| amt_i | input | 32 | Amount word; only the low byte is used |
| kind_i | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| c_i | input | 1 | Incoming carry flag |
| res_o | output | 32 | Shifted value |
| c_o | output | 1 | Outgoing carry flag |

## Verification
The block has no registers, so both outputs are due in the same cycle that the inputs are applied, after the combinational settling time. The bench drives each input set just after a rising clock edge and samples at the following falling edge, half a period later. No check depends on settling order at an edge. Every kind is swept over all 256 low-byte amounts on several operand patterns. Separate directed tasks cover the 0, 32, 33 and 255 boundaries, the rotate-by-multiple-of-32 case, and noise in the upper amount bits.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shf_kind_e;
endpackage

// File: rtl/shf_amount_decode.sv
module shf_amount_decode #(
  parameter int W     = 32,
  parameter int AMT_W = 32,
  parameter int CNT_W = 8,
  localparam int SH_W = $clog2(W)
) (
  input  logic [AMT_W-1:0] amt_i,
  output logic             is_zero_o,
  output logic             is_width_o,
  output logic             is_over_o,
  output logic [SH_W-1:0]  low_o
);
  logic [CNT_W-1:0] cnt;

  always_comb begin
    cnt        = amt_i[CNT_W-1:0];
    is_zero_o  = (cnt == '0);
    is_width_o = (cnt == CNT_W'(W));
    is_over_o  = (cnt > CNT_W'(W));
    low_o      = cnt[SH_W-1:0];
  end

  // R1: only the low byte drives the classification
  always_comb begin
    if (is_width_o) a_r1_width_low_zero: assert (low_o == '0);
  end
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
  parameter int W = 32,
  localparam int SH_W = $clog2(W)
) (
  input  logic [W-1:0]    vec_i,
  input  logic [SH_W-1:0] dist_i,
  input  logic            rot_i,
  input  logic            fill_i,
  output logic [W-1:0]    vec_o,
  output logic            last_out_o
);
  logic [W-1:0] stg [SH_W+1];
  logic [SH_W-1:0] last_idx;

  assign stg[0] = vec_i;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int D = 1 << s;
    logic [W-1:0] moved;
    always_comb begin
      if (rot_i) moved = {stg[s][D-1:0], stg[s][W-1:D]};
      else       moved = {{D{fill_i}}, stg[s][W-1:D]};
    end
    assign stg[s+1] = dist_i[s] ? moved : stg[s];
  end

  always_comb begin
    vec_o      = stg[SH_W];
    last_idx   = dist_i - SH_W'(1);
    last_out_o = vec_i[last_idx];
  end

  // R9: a rotation only moves bits, never creates or drops them
  always_comb begin
    if (rot_i) a_r9_rotate_keeps_ones: assert ($countones(vec_o) == $countones(vec_i));
  end
endmodule

// File: rtl/shf_reg_shifter.sv
module shf_reg_shifter
  import shf_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 32,
  parameter int CNT_W = 8,
  localparam int SH_W = $clog2(W)
) (
  input  logic [W-1:0]     opnd_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic [1:0]       kind_i,
  input  logic             c_i,
  output logic [W-1:0]     res_o,
  output logic             c_o
);
  shf_kind_e       kind;
  logic            is_zero, is_width, is_over;
  logic [SH_W-1:0] low;
  logic [W-1:0]    mirr_in, net_in, net_out, mirr_out, shifted;
  logic            net_rot, net_fill, net_carry, sign;

  assign kind = shf_kind_e'(kind_i);
  assign sign = opnd_i[W-1];

  shf_amount_decode #(.W(W), .AMT_W(AMT_W), .CNT_W(CNT_W)) u_dec (
    .amt_i      (amt_i),
    .is_zero_o  (is_zero),
    .is_width_o (is_width),
    .is_over_o  (is_over),
    .low_o      (low)
  );

  for (genvar i = 0; i < W; i++) begin : g_mirror
    assign mirr_in[i]  = opnd_i[W-1-i];
    assign mirr_out[i] = net_out[W-1-i];
  end

  always_comb begin
    net_in   = (kind == SK_LSL) ? mirr_in : opnd_i;
    net_rot  = (kind == SK_ROR);
    net_fill = (kind == SK_ASR) ? sign : 1'b0;
  end

  shf_barrel #(.W(W)) u_net (
    .vec_i      (net_in),
    .dist_i     (low),
    .rot_i      (net_rot),
    .fill_i     (net_fill),
    .vec_o      (net_out),
    .last_out_o (net_carry)
  );

  assign shifted = (kind == SK_LSL) ? mirr_out : net_out;

  always_comb begin
    res_o = shifted;
    c_o   = net_carry;
    if (is_zero) begin
      res_o = opnd_i;
      c_o   = c_i;
    end else begin
      unique case (kind)
        SK_LSL: if (is_width || is_over) begin
          res_o = '0;
          c_o   = is_width ? opnd_i[0] : 1'b0;
        end
        SK_LSR: if (is_width || is_over) begin
          res_o = '0;
          c_o   = is_width ? sign : 1'b0;
        end
        SK_ASR: if (is_width || is_over) begin
          res_o = {W{sign}};
          c_o   = sign;
        end
        SK_ROR: if (low == '0) begin
          res_o = opnd_i;
          c_o   = sign;
        end
        default: ;
      endcase
    end
  end

  // Port-level guards
  always_comb begin
    if (amt_i[CNT_W-1:0] == '0)
      a_r2_zero_keeps_all: assert (res_o == opnd_i && c_o == c_i);
    if (kind_i == 2'b00 && amt_i[CNT_W-1:0] > CNT_W'(W))
      a_r4_left_far_clears: assert (res_o == '0 && c_o == 1'b0);
    if (kind_i == 2'b01 && amt_i[CNT_W-1:0] > CNT_W'(W))
      a_r6_right_far_clears: assert (res_o == '0 && c_o == 1'b0);
    if (kind_i == 2'b10 && amt_i[CNT_W-1:0] >= CNT_W'(W))
      a_r8_arith_far_sign: assert (c_o == opnd_i[W-1] && (res_o == '0 || res_o == '1));
    if (kind_i == 2'b11 && amt_i[CNT_W-1:0] != '0 && amt_i[SH_W-1:0] == '0)
      a_r10_rotate_wrap_same: assert (res_o == opnd_i && c_o == opnd_i[W-1]);
  end
endmodule

// File: tb/sim_shf_reg_shifter.sv
module sim_shf_reg_shifter;
  logic        clk;
  logic        rst_n;
  logic [31:0] opnd_i, amt_i, res_o;
  logic [1:0]  kind_i;
  logic        c_i, c_o;
  int          n_chk, n_bad;
  bit          timed_out;

  shf_reg_shifter u0 (
    .opnd_i (opnd_i),
    .amt_i  (amt_i),
    .kind_i (kind_i),
    .c_i    (c_i),
    .res_o  (res_o),
    .c_o    (c_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] w,
                                        input logic [1:0] k, input logic ci);
    int n;
    int m;
    logic [32:0] t;
    logic [31:0] r;
    logic c;
    n = int'(w[7:0]);
    r = a;
    c = ci;
    if (n != 0) begin
      case (k)
        2'b00: if (n <= 32) begin
          t = {1'b0, a} << n; r = t[31:0]; c = t[32];
        end else begin r = 0; c = 0; end
        2'b01: if (n <= 32) begin
          t = {a, 1'b0} >> n; r = t[32:1]; c = t[0];
        end else begin r = 0; c = 0; end
        2'b10: if (n >= 32) begin
          r = {32{a[31]}}; c = a[31];
        end else begin
          t = 33'($signed({a, 1'b0}) >>> n); r = t[32:1]; c = t[0];
        end
        default: begin
          m = n % 32;
          if (m == 0) begin r = a; c = a[31]; end
          else begin r = (a >> m) | (a << (32 - m)); c = a[m-1]; end
        end
      endcase
    end
    return {c, r};
  endfunction

  task automatic apply_and_check(input string tag, input logic [31:0] a,
                                 input logic [31:0] w, input logic [1:0] k,
                                 input logic ci);
    logic [32:0] exp;
    @(posedge clk);
    #1;
    opnd_i = a; amt_i = w; kind_i = k; c_i = ci;
    @(negedge clk);
    exp = model(a, w, k, ci);
    n_chk++;
    if ({c_o, res_o} !== exp) begin
      n_bad++;
      $display("FAIL %s a=%h amt=%h kind=%0d cin=%0b: got res=%h c=%0b, expected res=%h c=%0b",
               tag, a, w, k, ci, res_o, c_o, exp[31:0], exp[32]);
    end
  endtask

  task automatic t_idle_state;
    apply_and_check("R2", 32'h0, 32'h0, 2'b00, 1'b0);
  endtask

  task automatic t_r1_upper_bits;
    apply_and_check("R1", 32'hA5A5_0F0F, 32'hFFFF_FF04, 2'b00, 1'b0);
    apply_and_check("R1", 32'hA5A5_0F0F, 32'h1234_5600, 2'b01, 1'b1);
    apply_and_check("R1", 32'h8000_0001, 32'h0000_0120, 2'b10, 1'b0);
    apply_and_check("R1", 32'h1234_5678, 32'h8000_0141, 2'b11, 1'b0);
  endtask

  task automatic t_r2_zero;
    for (int k = 0; k < 4; k++) begin
      apply_and_check("R2", 32'hDEAD_BEEF, 32'h0, 2'(k), 1'b1);
      apply_and_check("R2", 32'h0123_4567, 32'h0, 2'(k), 1'b0);
    end
  endtask

  task automatic t_r3_r4_left;
    apply_and_check("R3", 32'h8000_0001, 32'd1, 2'b00, 1'b0);
    apply_and_check("R3", 32'h0000_0001, 32'd31, 2'b00, 1'b0);
    apply_and_check("R4", 32'h0000_0001, 32'd32, 2'b00, 1'b0);
    apply_and_check("R4", 32'hFFFF_FFFF, 32'd33, 2'b00, 1'b1);
    apply_and_check("R4", 32'hFFFF_FFFF, 32'd255, 2'b00, 1'b1);
  endtask

  task automatic t_r5_r6_right;
    apply_and_check("R5", 32'h0000_0003, 32'd1, 2'b01, 1'b0);
    apply_and_check("R5", 32'hC000_0000, 32'd31, 2'b01, 1'b0);
    apply_and_check("R6", 32'h8000_0000, 32'd32, 2'b01, 1'b0);
    apply_and_check("R6", 32'hFFFF_FFFF, 32'd40, 2'b01, 1'b1);
  endtask

  task automatic t_r7_r8_arith;
    apply_and_check("R7", 32'h8000_00F0, 32'd4, 2'b10, 1'b1);
    apply_and_check("R7", 32'h7FFF_FFFF, 32'd31, 2'b10, 1'b0);
    apply_and_check("R8", 32'h8000_0000, 32'd32, 2'b10, 1'b0);
    apply_and_check("R8", 32'h7FFF_FFFF, 32'd200, 2'b10, 1'b1);
  endtask

  task automatic t_r9_r10_rotate;
    apply_and_check("R9", 32'h0000_0001, 32'd1, 2'b11, 1'b0);
    apply_and_check("R9", 32'h1234_5678, 32'd36, 2'b11, 1'b0);
    apply_and_check("R10", 32'h8000_0000, 32'd32, 2'b11, 1'b0);
    apply_and_check("R10", 32'h7FFF_FFFF, 32'd224, 2'b11, 1'b1);
  endtask

  task automatic t_sweep;
    logic [31:0] pats [3];
    pats[0] = 32'h8000_0001; pats[1] = 32'h5A3C_96E1; pats[2] = 32'h7FFF_FFFE;
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 4; k++)
        for (int n = 0; n < 256; n++)
          apply_and_check(k == 0 ? "R3/R4 sweep" : k == 1 ? "R5/R6 sweep" :
                          k == 2 ? "R7/R8 sweep" : "R9/R10 sweep",
                          pats[p], 32'(n) | 32'hC300_0000, 2'(k), n[0]);
  endtask

  initial begin
    timed_out = 1'b0;
    #150000;
    timed_out = 1'b1;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, got hang, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0;
    opnd_i = '0; amt_i = '0; kind_i = '0; c_i = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_idle_state();
    t_r1_upper_bits();
    t_r2_zero();
    t_r3_r4_left();
    t_r5_r6_right();
    t_r7_r8_arith();
    t_r9_r10_rotate();
    t_sweep();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule